// File: doc/BRIEF.md
# Codec Register Access Bridge

This block sits between a host register file and the command side of a serial audio/modem link, and lets software reach the 16-bit control registers of up to three attached codecs. Software places one 32-bit command word into the bridge. That word names the target codec, the direction, the register address and, for writes, the data, and it sets a go flag that starts the transfer. The same flag reads back as busy until the bridge can take another command.

While a transfer is running, the bridge presents a held request on its link-side port. The request stays up until the codec side acknowledges it. On a read acknowledge, the returned halfword is placed in a separate 32-bit response word together with a completion flag. If no acknowledge arrives within a programmable number of cycles, the bridge gives up, frees itself, and raises a timeout status bit that stays set until software clears it. A command that names a codec that does not exist finishes at once and causes no link activity. Software follows a fixed sequence: poll until busy is low, write the command, poll until busy is low again, and then, for a read, test the completion flag.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, the command readback, the response word, the timeout status and the link request are all zero.
- R2: A command write with the go bit (bit 8) set is accepted while idle. From the next cycle, readback bit 8 is 1 and the link request is high. The request carries codec = bits [1:0], read = bit 2, address = bits [15:9] and write data = bits [31:16] of the accepted word.
- R3: A command write whose go bit is 0 has no effect. Readback, response and link request are unchanged.
- R4: A command write while busy is ignored. The readback word and the link request fields of the transfer in flight do not change, and that transfer completes with its own result.
- R5: The link request and its fields are held until the cycle in which an acknowledge is sampled. Busy and the request both drop after that edge.
- R6: When a read is acknowledged, the response word holds the returned data in bits [31:16] and the completion flag (bit 8) is 1, from the same cycle in which busy reads 0.
- R7: When a write is acknowledged, the completion flag stays 0.
- R8: Accepting any command clears the completion flag and the response data to 0.
- R9: If the request has been high for `tmo_limit` cycles with no acknowledge, busy and the request drop, the completion flag stays 0 and the timeout status is set. A limit of 0 behaves as 1.
- R10: The timeout status stays set until `tmo_clr` is sampled high. A timeout in the same cycle as `tmo_clr` leaves the status set.
- R11: An acknowledge sampled in the same cycle as the timeout expiry wins. The transfer completes normally and no timeout is recorded.
- R12: An accepted command with codec select 3 never raises the link request. Busy reads 0 from the next cycle, and the readback shows the stored word with bit 8 clear.
- R13: An acknowledge while no request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Last accepted command, with bit 8 = busy |
| rsp_rdata | output | 32 | Response: [31:16] read data, bit 8 completion flag |
| tmo_limit | input | TMO_W | Cycles to wait for an acknowledge (0 acts as 1) |
| tmo_clr | input | 1 | Clears the sticky timeout status |
| tmo_status | output | 1 | Sticky timeout indication |
| lnk_req | output | 1 | Request pending toward the codec side |
| lnk_codec | output | 2 | Target codec of the pending request |
| lnk_rd | output | 1 | Pending request is a read |
| lnk_addr | output | 7 | Codec register address |
| lnk_wdata | output | 16 | Write data of the pending request |
| lnk_ack | input | 1 | Codec side has completed the request |
| lnk_rdata | input | 16 | Read data, valid with lnk_ack |

## Verification
The acknowledge and the timeout expiry can land on the same clock edge. Both of them finish the transfer, and they disagree about the result. The bench provokes this by setting the responding codec model's delay so that its acknowledge is sampled on exactly the edge where the wait counter reaches the limit. It then requires a valid read with the expected data and a clear timeout status. Two neighbouring cases pin down the boundary: a delay one cycle longer must time out, and a clear request held through the expiry edge must leave the status set.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
    // command / response word layout (software visible)
    localparam int WORD_W   = 32;
    localparam int SEL_LSB  = 0;
    localparam int SEL_W    = 2;
    localparam int RD_POS   = 2;
    localparam int GO_POS   = 8;
    localparam int ADDR_LSB = 9;
    localparam int DATA_LSB = 16;
    localparam int REG_W    = WORD_W - DATA_LSB;
    localparam int ADDR_W   = DATA_LSB - ADDR_LSB;
    localparam int VLD_POS  = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              rd;
        logic              go;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } cmd_t;
endpackage

// File: rtl/cbr_cmd_decode.sv
`timescale 1ns/1ps
module cbr_cmd_decode
    import cbr_pkg::*;
#(
    parameter int NUM_CODECS = 3
) (
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd,
    output logic              legal,
    output logic [WORD_W-1:0] stored
);
    localparam logic [SEL_W:0] NUM_V = NUM_CODECS[SEL_W:0];

    always_comb begin
        cmd.sel  = word[SEL_LSB +: SEL_W];
        cmd.rd   = word[RD_POS];
        cmd.go   = word[GO_POS];
        cmd.addr = word[ADDR_LSB +: ADDR_W];
        cmd.data = word[DATA_LSB +: REG_W];
        legal    = ({1'b0, cmd.sel} < NUM_V);
        // go flag is not kept: busy is reinserted on readback
        stored         = word;
        stored[GO_POS] = 1'b0;
    end
endmodule

// File: rtl/cbr_timer.sv
`timescale 1ns/1ps
module cbr_timer #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tmr_s;

    tmr_s             tmr_d, tmr_q;
    logic [TMO_W-1:0] last_d;

    always_comb begin
        last_d = (limit == '0) ? '0 : limit - 1'b1;
        expire = run && (tmr_q.cnt == last_d);
        tmr_d  = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
        end else if (run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/cbr_ctrl.sv
`timescale 1ns/1ps
module cbr_ctrl
    import cbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  cmd_t              cmd,
    input  logic              legal,
    input  logic [WORD_W-1:0] stored,
    input  logic              lnk_ack,
    input  logic [REG_W-1:0]  lnk_rdata,
    input  logic              expire,
    input  logic              tmo_clr,
    output logic              accept,
    output logic              busy,
    output logic [WORD_W-1:0] word_q,
    output logic [REG_W-1:0]  rdat_q,
    output logic              vld_q,
    output logic              tmo_q
);
    typedef struct packed {
        st_e               st;
        logic [WORD_W-1:0] word;
        logic [REG_W-1:0]  rdat;
        logic              vld;
        logic              tmo;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d    = c_q;
        accept = cmd_wr && cmd.go && (c_q.st == ST_IDLE);

        if (tmo_clr) begin
            c_d.tmo = 1'b0;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.word = stored;
                    c_d.rdat = '0;
                    c_d.vld  = 1'b0;
                    if (legal) begin
                        c_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (lnk_ack) begin
                    c_d.st = ST_IDLE;
                    if (c_q.word[RD_POS]) begin
                        c_d.rdat = lnk_rdata;
                        c_d.vld  = 1'b1;
                    end
                end else if (expire) begin
                    c_d.st  = ST_IDLE;
                    c_d.tmo = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, word: '0, rdat: '0, vld: 1'b0, tmo: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy   = (c_q.st == ST_WAIT);
    assign word_q = c_q.word;
    assign rdat_q = c_q.rdat;
    assign vld_q  = c_q.vld;
    assign tmo_q  = c_q.tmo;
endmodule

// File: rtl/codec_reg_bridge.sv
`timescale 1ns/1ps
module codec_reg_bridge
    import cbr_pkg::*;
#(
    parameter int NUM_CODECS = 3,
    parameter int TMO_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [31:0]               cmd_wdata,
    output logic [31:0]               cmd_rdata,
    output logic [31:0]               rsp_rdata,
    input  logic [TMO_W-1:0]          tmo_limit,
    input  logic                      tmo_clr,
    output logic                      tmo_status,
    output logic                      lnk_req,
    output logic [1:0]                lnk_codec,
    output logic                      lnk_rd,
    output logic [6:0]                lnk_addr,
    output logic [15:0]               lnk_wdata,
    input  logic                      lnk_ack,
    input  logic [15:0]               lnk_rdata
);
    cmd_t              dec_cmd;
    logic              dec_legal;
    logic [WORD_W-1:0] dec_stored;
    logic              accept;
    logic              busy;
    logic [WORD_W-1:0] word_q;
    logic [REG_W-1:0]  rdat_q;
    logic              vld_q;
    logic              tmo_q;
    logic              expire;

    cbr_cmd_decode #(.NUM_CODECS(NUM_CODECS)) u_dec (
        .word   (cmd_wdata),
        .cmd    (dec_cmd),
        .legal  (dec_legal),
        .stored (dec_stored)
    );

    cbr_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .run    (busy),
        .limit  (tmo_limit),
        .expire (expire)
    );

    cbr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd       (dec_cmd),
        .legal     (dec_legal),
        .stored    (dec_stored),
        .lnk_ack   (lnk_ack),
        .lnk_rdata (lnk_rdata),
        .expire    (expire),
        .tmo_clr   (tmo_clr),
        .accept    (accept),
        .busy      (busy),
        .word_q    (word_q),
        .rdat_q    (rdat_q),
        .vld_q     (vld_q),
        .tmo_q     (tmo_q)
    );

    always_comb begin
        cmd_rdata         = word_q;
        cmd_rdata[GO_POS] = busy;
        rsp_rdata                     = '0;
        rsp_rdata[DATA_LSB +: REG_W]  = rdat_q;
        rsp_rdata[VLD_POS]            = vld_q;
    end

    assign tmo_status = tmo_q;
    assign lnk_req    = busy;
    assign lnk_codec  = word_q[SEL_LSB +: SEL_W];
    assign lnk_rd     = word_q[RD_POS];
    assign lnk_addr   = word_q[ADDR_LSB +: ADDR_W];
    assign lnk_wdata  = word_q[DATA_LSB +: REG_W];
endmodule

// File: rtl/cbr_checker.sv
`timescale 1ns/1ps
module cbr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_rdata,
    input logic [31:0] rsp_rdata,
    input logic        tmo_clr,
    input logic        tmo_status,
    input logic        lnk_req,
    input logic [1:0]  lnk_codec,
    input logic        lnk_rd,
    input logic [6:0]  lnk_addr,
    input logic [15:0] lnk_wdata,
    input logic        lnk_ack,
    input logic [15:0] lnk_rdata
);
    AST_BUSY_SHOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req |-> cmd_rdata[8]); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && !lnk_ack && cmd_wr) |=> (lnk_req ? ($stable(lnk_addr) && $stable(lnk_codec) && $stable(lnk_wdata) && $stable(lnk_rd)) : 1'b1)); // R4

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && lnk_ack) |=> !lnk_req); // R5

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && lnk_ack && lnk_rd) |=> (rsp_rdata[8] && rsp_rdata[31:16] == $past(lnk_rdata))); // R6

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && lnk_ack && !lnk_rd) |=> !rsp_rdata[8]); // R7

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[8] |-> !cmd_rdata[8]); // R8

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_status && !tmo_clr) |=> tmo_status); // R10

    AST_ACK_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && lnk_ack && !tmo_status) |=> !tmo_status); // R11

    AST_NO_ILLEGAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req |-> (lnk_codec != 2'd3)); // R12
endmodule

bind codec_reg_bridge cbr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_rdata  (cmd_rdata),
    .rsp_rdata  (rsp_rdata),
    .tmo_clr    (tmo_clr),
    .tmo_status (tmo_status),
    .lnk_req    (lnk_req),
    .lnk_codec  (lnk_codec),
    .lnk_rd     (lnk_rd),
    .lnk_addr   (lnk_addr),
    .lnk_wdata  (lnk_wdata),
    .lnk_ack    (lnk_ack),
    .lnk_rdata  (lnk_rdata)
);

// File: tb/codec_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module codec_reg_bridge_tb_top;
    localparam int TMO_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmd_wr;
    logic [31:0]      cmd_wdata;
    logic [31:0]      cmd_rdata;
    logic [31:0]      rsp_rdata;
    logic [TMO_W-1:0] tmo_limit;
    logic             tmo_clr;
    logic             tmo_status;
    logic             lnk_req;
    logic [1:0]       lnk_codec;
    logic             lnk_rd;
    logic [6:0]       lnk_addr;
    logic [15:0]      lnk_wdata;
    logic             lnk_ack;
    logic [15:0]      lnk_rdata;

    always #2.5 clk = ~clk;

    codec_reg_bridge #(.NUM_CODECS(3), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .rsp_rdata(rsp_rdata), .tmo_limit(tmo_limit),
        .tmo_clr(tmo_clr), .tmo_status(tmo_status), .lnk_req(lnk_req),
        .lnk_codec(lnk_codec), .lnk_rd(lnk_rd), .lnk_addr(lnk_addr),
        .lnk_wdata(lnk_wdata), .lnk_ack(lnk_ack), .lnk_rdata(lnk_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int c, input bit rd, input bit go,
                                       input int a, input logic [15:0] d);
        return {d, 7'(a), go, 5'b0, rd, 2'(c)};
    endfunction

    function automatic logic [15:0] seed(input int c, input int a);
        return 16'(c * 4096 + a * 37 + 5);
    endfunction

    // codec-side model
    logic [15:0] mdl_mem [0:3][0:127];
    logic [15:0] shadow  [0:3][0:127];
    bit  mdl_on;
    int  mdl_dly;
    int  mdl_w;
    logic mdl_ack;
    logic spur_ack;
    assign lnk_ack = mdl_ack | spur_ack;

    always @(negedge clk) begin
        if (!rst_n || !lnk_req || mdl_ack) begin
            mdl_ack <= 1'b0;
            mdl_w   <= 0;
        end else if (mdl_on) begin
            if (mdl_w == mdl_dly) begin
                mdl_ack   <= 1'b1;
                lnk_rdata <= mdl_mem[lnk_codec][lnk_addr];
                if (!lnk_rd) mdl_mem[lnk_codec][lnk_addr] <= lnk_wdata;
            end else begin
                mdl_w <= mdl_w + 1;
            end
        end
    end

    // scoreboard
    typedef struct {
        bit          vld;
        logic [15:0] data;
        bit          tmo;
    } exp_t;
    exp_t sbq[$];
    logic prev_busy = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy && !cmd_rdata[8]) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R5", "completion with empty queue", 32'(cmd_rdata), 32'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (e.tmo) begin
                        chk(tmo_status == 1'b1 && !rsp_rdata[8], "R9", "timeout result",
                            {rsp_rdata[31:1], tmo_status}, 32'h1);
                    end else if (e.vld) begin
                        chk(rsp_rdata[8] && rsp_rdata[31:16] == e.data, "R6", "read result",
                            rsp_rdata, {e.data, 7'b0, 1'b1, 8'b0});
                    end else begin
                        chk(!rsp_rdata[8], "R7", "write completion flag",
                            32'(rsp_rdata[8]), 32'h0);
                    end
                end
            end
            prev_busy <= cmd_rdata[8];
        end
    end

    task automatic issue(input int c, input bit rd, input int a,
                         input logic [15:0] d, input bit exp_tmo);
        exp_t e;
        while (cmd_rdata[8]) @(negedge clk);
        e.tmo  = exp_tmo;
        e.vld  = rd && !exp_tmo;
        e.data = shadow[c][a];
        if (!rd && !exp_tmo) shadow[c][a] = d;
        sbq.push_back(e);
        cmd_wdata = mk(c, rd, 1'b1, a, d);
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic wait_done();
        while (cmd_rdata[8]) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_req(output int n);
        n = 0;
        while (lnk_req && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        int n;
        logic [31:0] saved;
        logic [31:0] rsp_saved;
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 128; a++) begin
                mdl_mem[c][a] = seed(c, a);
                shadow[c][a]  = seed(c, a);
            end
        end
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; tmo_limit = 12'd20;
        tmo_clr = 1'b0; spur_ack = 1'b0; mdl_on = 1'b1; mdl_dly = 2;
        lnk_rdata = '0;
        repeat (3) @(negedge clk);
        chk(cmd_rdata == 0 && rsp_rdata == 0, "R1", "reset words", cmd_rdata | rsp_rdata, 32'h0);
        chk(!tmo_status && !lnk_req, "R1", "reset status/request", {tmo_status, lnk_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: accepted write presents its fields
        issue(1, 1'b0, 7'h12, 16'hBEEF, 1'b0);
        chk(lnk_req && cmd_rdata[8], "R2", "request/busy", {lnk_req, cmd_rdata[8]}, 32'h3);
        chk({lnk_codec, lnk_rd, lnk_addr, lnk_wdata} == {2'd1, 1'b0, 7'h12, 16'hBEEF},
            "R2", "link fields", 32'({lnk_codec, lnk_rd, lnk_addr, lnk_wdata}),
            32'({2'd1, 1'b0, 7'h12, 16'hBEEF}));
        wait_done();

        // R6: read back via scoreboard and directly
        issue(1, 1'b1, 7'h12, 16'h0, 1'b0);
        wait_done();
        chk(rsp_rdata == 32'hBEEF_0100, "R6", "read response word", rsp_rdata, 32'hBEEF_0100);

        // R8 / R7: accepted write clears completion, stays clear
        issue(0, 1'b0, 5, 16'h1234, 1'b0);
        chk(rsp_rdata == 0, "R8", "response cleared on accept", rsp_rdata, 32'h0);
        wait_done();
        chk(!rsp_rdata[8], "R7", "flag after write", 32'(rsp_rdata[8]), 32'h0);

        // R5: request held for delay+1 cycles
        mdl_dly = 6;
        issue(2, 1'b1, 7'h7F, 16'h0, 1'b0);
        count_req(n);
        chk(n == 7, "R5", "request length", 32'(n), 32'd7);
        wait_done();

        // R4: write while busy ignored
        mdl_dly = 5;
        issue(0, 1'b1, 3, 16'h0, 1'b0);
        saved = cmd_rdata;
        cmd_wdata = mk(2, 1'b0, 1'b1, 9, 16'hAAAA);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(cmd_rdata == saved, "R4", "readback while busy", cmd_rdata, saved);
        chk(lnk_addr == 7'd3 && lnk_codec == 2'd0, "R4", "link fields while busy",
            32'({lnk_codec, lnk_addr}), 32'({2'd0, 7'd3}));
        wait_done();

        // R3: go bit clear has no effect
        saved = cmd_rdata;
        rsp_saved = rsp_rdata;
        cmd_wdata = mk(1, 1'b1, 1'b0, 20, 16'h5555);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        chk(cmd_rdata == saved && rsp_rdata == rsp_saved && !lnk_req, "R3", "no-go write",
            cmd_rdata, saved);

        // R12: codec select 3
        cmd_wdata = mk(3, 1'b1, 1'b1, 10, 16'h0);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(cmd_rdata == mk(3, 1'b1, 1'b0, 10, 16'h0), "R12", "stored illegal word",
            cmd_rdata, mk(3, 1'b1, 1'b0, 10, 16'h0));
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (lnk_req) n++;
            @(negedge clk);
        end
        chk(n == 0 && !rsp_rdata[8], "R12", "no link activity", 32'(n), 32'h0);

        // R13: spurious acknowledge while idle
        rsp_saved = rsp_rdata;
        saved = cmd_rdata;
        spur_ack = 1'b1;
        repeat (2) @(negedge clk);
        spur_ack = 1'b0;
        @(negedge clk);
        chk(rsp_rdata == rsp_saved && cmd_rdata == saved, "R13", "idle ack ignored",
            rsp_rdata, rsp_saved);

        // R9: timeout after limit cycles
        mdl_on = 1'b0;
        tmo_limit = 12'd5;
        issue(1, 1'b1, 30, 16'h0, 1'b1);
        count_req(n);
        chk(n == 5, "R9", "request length before timeout", 32'(n), 32'd5);
        chk(tmo_status && !rsp_rdata[8], "R9", "timeout flags",
            {rsp_rdata[8], tmo_status}, 32'h1);

        // R10: sticky across a good transfer, then cleared
        mdl_on = 1'b1; mdl_dly = 1; tmo_limit = 12'd20;
        issue(2, 1'b0, 40, 16'h7777, 1'b0);
        wait_done();
        chk(tmo_status, "R10", "status held", 32'(tmo_status), 32'h1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;
        chk(!tmo_status, "R10", "status cleared", 32'(tmo_status), 32'h0);

        // R10: set wins over clear in the same cycle
        mdl_on = 1'b0; tmo_limit = 12'd2;
        issue(0, 1'b0, 50, 16'h1111, 1'b1);
        tmo_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tmo_clr = 1'b0;
        chk(tmo_status && !lnk_req, "R10", "set beats clear", {lnk_req, tmo_status}, 32'h1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;

        // R9: zero limit acts as one
        tmo_limit = 12'd0;
        issue(1, 1'b1, 60, 16'h0, 1'b1);
        count_req(n);
        chk(n == 1 && tmo_status, "R9", "zero limit", 32'(n), 32'd1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;

        // R11: acknowledge on the expiry edge wins
        mdl_on = 1'b1; mdl_dly = 3; tmo_limit = 12'd4;
        issue(2, 1'b1, 7'h40, 16'h0, 1'b0);
        wait_done();
        chk(!tmo_status && rsp_rdata[8], "R11", "ack at expiry",
            {rsp_rdata[8], tmo_status}, 32'h2);

        // R9: one cycle later it times out
        mdl_dly = 4;
        issue(0, 1'b1, 7'h41, 16'h0, 1'b1);
        wait_done();
        chk(tmo_status, "R9", "ack one cycle late", 32'(tmo_status), 32'h1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;

        // fast back-to-back reads
        mdl_dly = 0; tmo_limit = 12'd20;
        for (int k = 0; k < 4; k++) begin
            issue(k % 3, 1'b1, 7'(k * 9 + 1), 16'h0, 1'b0);
        end
        wait_done();
        chk(sbq.size() == 0, "R6", "scoreboard drained", 32'(sbq.size()), 32'h0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule